// File: doc/BRIEF.md
# Four-Channel Staged Converter Register Front End

This block is the register-side front end of a four-channel, 12-bit output converter group (channels A, B, C and D). A 16-bit register bus writes a mode register, a shared range word carrying one polarity bit and one gain bit per channel, and one data word per channel. Writes only fill holding (staged) registers. The values that drive the converters change in one of two ways. A read access to the range address copies the staged range word into the active range outputs. A read access to the mode address copies all four staged data words into the active data outputs in the same cycle.

The mode register holds an output-enable bit and a staged-mode bit. With staged mode off, a data write also lands directly in that channel's active register. With the enable low, every channel's code output is replaced by the code for zero volts in its present polarity: 0x000 when unipolar, 0x800 (mid-scale, offset binary) when bipolar. The converters themselves sit outside the block. Channel A is index 0 of every per-channel output.

Top module: `dacq_quad_dac`

## Requirements
- R1: After synchronous reset, all staged and active registers are zero. Every channel is unipolar with gain 0, the enable and staged-mode bits are 0, and every code output is 0x000.
- R2: A write to byte address 0x12 changes no output. A later read of 0x12 makes the staged word active. Polarity for A, B, C, D is taken from bits 7, 6, 5, 4 (1 = bipolar) and gain from bits 11, 10, 9, 8.
- R3: With staged mode on (bit 0 of the word written to address 0x02), a write to a data address (A 0x14, B 0x16, C 0x18, D 0x1A) leaves every active code unchanged.
- R4: A read of address 0x02 copies all four staged data words to the active registers on the same clock edge.
- R5: With staged mode off, a data write updates only that channel's active code, visible from the next cycle.
- R6: Only the low 12 bits of a data write are kept; bits 15:12 are dropped.
- R7: While the enable (bit 1 of the mode word) is 0, each code output is 0x800 if that channel is active-bipolar and 0x000 otherwise. While it is 1, each code output shows the active data word.
- R8: Writing 0x0000 to the range address and then reading it returns every channel to unipolar with gain 0.
- R9: Accesses to any other address, writes that are not to the data, range or mode addresses, and reads that are not to 0x02 or 0x12 leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| dac_code | output | 48 | Code per channel, 12 bits each, A in bits 11:0 |
| dac_bipolar | output | 4 | Active polarity per channel (bit 0 = A) |
| dac_gain | output | 4 | Active gain per channel (bit 0 = A) |
| dac_enable | output | 1 | Active output-enable bit |

## Verification
The hardest case to reach is a data commit in which all four channels move together while their staged and active words all differ. That case needs staged mode on, four distinct staged writes, and no intervening commit. The bench sets it up with a directed sequence first. It then runs random traffic weighted toward the mode, range and data addresses, so that commits, direct writes and enable toggles interleave with mixed polarities. Checking the enable-low case against a bipolar channel shows whether the forced zero code follows the active range word rather than the staged one.

// File: rtl/dacq_pkg.sv
package dacq_pkg;

    localparam int CH_COUNT   = 4;
    localparam int CODE_W     = 12;
    localparam int REG_W      = 16;

    // Range word layout: channel c uses bit (TOP - c)
    localparam int POL_TOP    = 7;
    localparam int GAIN_TOP   = 11;

    // Mode word layout
    localparam int MODE_EN_BIT  = 1;
    localparam int MODE_BUF_BIT = 0;

    // Byte offsets
    localparam int OFS_MODE    = 'h02;
    localparam int OFS_RANGE   = 'h12;
    localparam int OFS_DATA0   = 'h14;
    localparam int DATA_STRIDE = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic out_en;
        logic staged;
    } mode_t;

    typedef struct packed {
        logic [CH_COUNT-1:0] bip;
        logic [CH_COUNT-1:0] gain;
    } range_t;

    typedef struct packed {
        logic                wr_mode;
        logic                wr_range;
        logic                go_range;
        logic                go_data;
        logic [CH_COUNT-1:0] wr_data;
    } strobe_t;

    function automatic int pol_pos(input int ch);
        return POL_TOP - ch;
    endfunction

    function automatic int gain_pos(input int ch);
        return GAIN_TOP - ch;
    endfunction

    function automatic code_t zero_code(input logic bip);
        return bip ? code_t'(1) << (CODE_W - 1) : '0;
    endfunction

endpackage

// File: rtl/dacq_regdec.sv
module dacq_regdec
    import dacq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output strobe_t           strb
);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_RANGE = ADDR_W'(OFS_RANGE);

    logic [CH_COUNT-1:0] dwr;

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_dsel
        localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA0 + DATA_STRIDE * c);
        assign dwr[c] = bus_sel && bus_we && (bus_addr == A_DATA);
    end

    always_comb begin
        strb          = '0;
        strb.wr_mode  = bus_sel &&  bus_we && (bus_addr == A_MODE);
        strb.wr_range = bus_sel &&  bus_we && (bus_addr == A_RANGE);
        strb.go_data  = bus_sel && !bus_we && (bus_addr == A_MODE);
        strb.go_range = bus_sel && !bus_we && (bus_addr == A_RANGE);
        strb.wr_data  = dwr;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strb.wr_mode, strb.wr_range, strb.go_range, strb.go_data, strb.wr_data})); // R9

endmodule

// File: rtl/dacq_range.sv
module dacq_range
    import dacq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          strb,
    input  logic [REG_W-1:0] wdata,
    output mode_t            mode,
    output range_t           rng_act
);
    range_t rng_stg;
    range_t rng_in;

    always_comb begin
        rng_in = '0;
        for (int c = 0; c < CH_COUNT; c++) begin
            rng_in.bip[c]  = wdata[pol_pos(c)];
            rng_in.gain[c] = wdata[gain_pos(c)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= '0;
            rng_stg <= '0;
            rng_act <= '0;
        end else begin
            if (strb.wr_mode) begin
                mode.out_en <= wdata[MODE_EN_BIT];
                mode.staged <= wdata[MODE_BUF_BIT];
            end
            if (strb.wr_range) rng_stg <= rng_in;
            if (strb.go_range) rng_act <= rng_stg;
        end
    end

    AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strb.go_range |=> $stable(rng_act)); // R2
    AST_RANGE_LOAD: assert property (@(posedge clk) disable iff (rst)
        strb.go_range |=> rng_act == $past(rng_stg)); // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strb.wr_mode |=> $stable(mode)); // R9

endmodule

// File: rtl/dacq_chan.sv
module dacq_chan
    import dacq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             go,
    input  logic             staged,
    input  logic [REG_W-1:0] wdata,
    output code_t            act
);
    code_t stg;
    code_t din;

    assign din = wdata[CODE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
            act <= '0;
        end else begin
            if (wr) stg <= din;
            if (go)
                act <= stg;
            else if (wr && !staged)
                act <= din;
        end
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr && staged) |=> $stable(act)); // R3
    AST_DATA_COMMIT: assert property (@(posedge clk) disable iff (rst)
        go |=> act == $past(stg)); // R4
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && !staged) |=> act == $past(wdata[CODE_W-1:0])); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr && !go) |=> $stable(act)); // R5

endmodule

// File: rtl/dacq_quad_dac.sv
module dacq_quad_dac
    import dacq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_sel,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [REG_W-1:0]           bus_wdata,
    output logic [CH_COUNT*CODE_W-1:0] dac_code,
    output logic [CH_COUNT-1:0]        dac_bipolar,
    output logic [CH_COUNT-1:0]        dac_gain,
    output logic                       dac_enable
);
    strobe_t strb;
    mode_t   mode;
    range_t  rng_act;

    dacq_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .strb     (strb)
    );

    dacq_range u_rng (
        .clk     (clk),
        .rst     (rst),
        .strb    (strb),
        .wdata   (bus_wdata),
        .mode    (mode),
        .rng_act (rng_act)
    );

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
        code_t act;

        dacq_chan u_ch (
            .clk    (clk),
            .rst    (rst),
            .wr     (strb.wr_data[c]),
            .go     (strb.go_data),
            .staged (mode.staged),
            .wdata  (bus_wdata),
            .act    (act)
        );

        assign dac_code[c*CODE_W +: CODE_W] =
            mode.out_en ? act : zero_code(rng_act.bip[c]);

        AST_ZERO_FORCE: assert property (@(posedge clk) disable iff (rst)
            !dac_enable |-> dac_code[c*CODE_W +: CODE_W-1] == '0); // R7
    end

    assign dac_bipolar = rng_act.bip;
    assign dac_gain    = rng_act.gain;
    assign dac_enable  = mode.out_en;

endmodule

// File: tb/tb_dacq_quad_dac.sv
`timescale 1ns/1ps
module tb_dacq_quad_dac;
    import dacq_pkg::*;

    localparam int AW = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                       rst;
    logic                       bus_sel;
    logic                       bus_we;
    logic [AW-1:0]              bus_addr;
    logic [REG_W-1:0]           bus_wdata;
    logic [CH_COUNT*CODE_W-1:0] dac_code;
    logic [CH_COUNT-1:0]        dac_bipolar;
    logic [CH_COUNT-1:0]        dac_gain;
    logic                       dac_enable;

    dacq_quad_dac #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dac_code(dac_code),
        .dac_bipolar(dac_bipolar), .dac_gain(dac_gain), .dac_enable(dac_enable)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model, channel A at index 0
    logic [11:0] m_stg [4];
    logic [11:0] m_act [4];
    logic [3:0]  m_sbip, m_sgain, m_bip, m_gain;
    logic        m_en, m_buf;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_code(input int ch);
        if (m_en) return int'(m_act[ch]);
        return m_bip[ch] ? 'h800 : 0;
    endfunction

    task automatic check_all(input string req);
        for (int c = 0; c < 4; c++)
            chk(req, $sformatf("code[%0d]", c), int'(dac_code[c*12 +: 12]), exp_code(c));
        chk(req, "bipolar", int'(dac_bipolar), int'(m_bip));
        chk(req, "gain", int'(dac_gain), int'(m_gain));
        chk(req, "enable", int'(dac_enable), int'(m_en));
    endtask

    function automatic void model(input bit we, input int a, input logic [15:0] d);
        if (we) begin
            if (a == 'h02) begin m_en = d[1]; m_buf = d[0]; end
            else if (a == 'h12) begin
                for (int c = 0; c < 4; c++) begin
                    m_sbip[c]  = d[7 - c];
                    m_sgain[c] = d[11 - c];
                end
            end else if (a >= 'h14 && a <= 'h1A && a[0] == 1'b0) begin
                m_stg[(a - 'h14) / 2] = d[11:0];
                if (!m_buf) m_act[(a - 'h14) / 2] = d[11:0];
            end
        end else begin
            if (a == 'h02) for (int c = 0; c < 4; c++) m_act[c] = m_stg[c];
            else if (a == 'h12) begin m_bip = m_sbip; m_gain = m_sgain; end
        end
    endfunction

    task automatic access(input bit we, input int a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = AW'(a); bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        model(we, a, d);
    endtask

    function automatic void model_reset();
        for (int c = 0; c < 4; c++) begin m_stg[c] = '0; m_act[c] = '0; end
        m_sbip = '0; m_sgain = '0; m_bip = '0; m_gain = '0; m_en = 0; m_buf = 0;
    endfunction

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int seed;
        bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check_all("R1");

        // R2: staged range word has no effect until committed
        access(1, 'h12, 16'h00F0);
        check_all("R2 staged only");
        access(0, 'h12, 16'h0);
        check_all("R2 commit");
        // R7: disabled, bipolar channels show mid-scale
        chk("R7", "code A forced", int'(dac_code[11:0]), 'h800);

        // R2 bit mapping: gain 1010 on 11..8, polarity 0101 on 7..4
        access(1, 'h12, 16'h0A50);
        access(0, 'h12, 16'h0);
        chk("R2", "bipolar map", int'(dac_bipolar), 'b1010);
        chk("R2", "gain map", int'(dac_gain), 'b0101);

        // R5/R6: enable, direct mode, upper bits dropped
        access(1, 'h02, 16'h0002);
        access(1, 'h14, 16'hFABC);
        check_all("R5 direct A");
        chk("R6", "code A low bits", int'(dac_code[11:0]), 'hABC);
        access(1, 'h1A, 16'h7123);
        check_all("R6 direct D");

        // R3/R4: staged mode, four distinct words, then one commit
        access(1, 'h02, 16'h0003);
        access(1, 'h14, 16'h0111);
        access(1, 'h16, 16'h0222);
        access(1, 'h18, 16'h0333);
        access(1, 'h1A, 16'h0444);
        check_all("R3 staged hold");
        access(0, 'h02, 16'h0);
        check_all("R4 commit all");
        chk("R4", "code D", int'(dac_code[47:36]), 'h444);

        // R9: foreign addresses and wrong-direction accesses
        access(1, 'h04, 16'hFFFF);
        access(0, 'h14, 16'h0);
        access(1, 'h3E, 16'hFFFF);
        access(1, 'h15, 16'hFFFF);
        check_all("R9 no effect");

        // R7: disable with mixed polarity, then re-enable
        access(1, 'h02, 16'h0001);
        check_all("R7 disabled");
        access(1, 'h02, 16'h0003);
        check_all("R7 enabled");

        // R8: zero range word
        access(1, 'h12, 16'h0000);
        access(0, 'h12, 16'h0);
        check_all("R8 cleared");

        // random traffic
        seed = 7;
        void'($urandom(seed));
        for (int i = 0; i < 400; i++) begin
            int pick;
            int a;
            pick = int'($urandom_range(0, 9));
            case (pick)
                0, 1: a = 'h02;
                2, 3: a = 'h12;
                9:    a = int'($urandom_range(0, 63));
                default: a = 'h14 + 2 * int'($urandom_range(0, 3));
            endcase
            access($urandom_range(0, 2) != 0, a, 16'($urandom()));
            check_all("R9 random");
        end

        finish_run();
    end

endmodule